// File: doc/BRIEF.md
# SMBus Master Byte Controller

This block is the register-facing half of an SMBus/I2C master. Software talks to it through a small 8-bit register port. It sets command bits to open a transfer and writes the address and data bytes. It reads received bytes and watches a status register and an interrupt line. Toward the wire, the block does no bit timing. It hands one operation at a time to a bit-level engine: generate START, shift out a byte, shift in a byte (with ACK or NACK), or generate STOP. The engine signals completion with a one-cycle done pulse, which carries the acknowledge seen on a written byte or the byte it received.

The controller moves through the phases of a transfer. These are START, the address byte, optional stall after an acknowledged address, transmit or receive bytes, NACK on the last received byte, and STOP. Status is kept in flags that software clears by writing ones. The START and STOP command bits clear themselves. A STOP requested during a read is held back until the final received byte has been taken from the data register. A STOP requested after a refused address waits until the negative-ack flag is cleared.

Top module: `smb_master_ctl`

## Requirements
- R1: While the enable bit (control2 offset 0xA, bit 0) is 0, the registers at control1 (0x6), status (0x2), control-status (0x4) and control-status-3 (0x19) all read 0. Writes to control1 are ignored and no bus operation is started.
- R2: Writing control1 with START (bit 0) issues one START operation. Once it completes, status (0x2) reads 0x43 (SDA-ready bit 6, master bit 1, transmit bit 0) and control-status reads 0x03 (bus-busy bit 1, module-busy bit 0). With int-enable (control1 bit 2) set, irq is high.
- R3: Control1 bits 7..2 read back as written, and the STOP (bit 1) and START (bit 0) bits always read 0.
- R4: If the address byte is not acknowledged, status reads 0x13 for a write address (negative-ack bit 4, master, transmit) and irq is high with int-enable set.
- R5: A STOP requested while negative-ack is set is held back. The busy bits stay set until 1 is written to status bit 4. The STOP then runs, after which status and control-status read 0 and control-status-3 reads 0x80 (end-of-busy, bit 7).
- R6: Writing 0x80 to control-status-3 clears end-of-busy. With end-of-busy int-enable (control1 bit 3) set, irq is high while end-of-busy is set.
- R7: The address byte written to data (0x0) is the 7-bit address shifted left by one, with bit 0 set for a read, and it is passed to the engine unchanged. When the address is acknowledged with stall-enable (control1 bit 7) set, status reads 0x4B for a write. Writing 1 to status bit 3 clears the stall, and status then reads 0x43.
- R8: A data-register write that arrives while a bus operation is in flight is ignored and sends no byte to the engine.
- R9: A START written while the bus is still busy runs a repeated START, and status again reads 0x43 afterwards.
- R10: An acknowledged read address with stall-enable set gives status 0x4A (SDA-ready, stall, master).
- R11: Clearing the stall after a read address starts a byte receive that carries the control1 ACK bit (bit 4) as its NACK request. Once it completes, status reads 0x42 and the data register returns the received byte.
- R12: A STOP requested after the NACKed byte arrives leaves both busy bits set until the data register is read. Only then does the STOP run and end-of-busy set.
- R13: With stall-enable clear, an acknowledged read address starts the first receive at once. Reading the data register starts the next receive unless the previous one was NACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data reads have side effects) |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cmd_valid | output | 1 | One-cycle request to the bit engine |
| cmd_op | output | 2 | Operation: 0 START, 1 write byte, 2 read byte, 3 STOP |
| cmd_byte | output | 8 | Byte to shift out for a write |
| cmd_nack | output | 1 | For a read, answer the byte with NACK |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_ack | input | 1 | Acknowledge seen on a written byte |
| eng_rdata | input | 8 | Byte received by a read operation |
| irq | output | 1 | Interrupt request |

## Verification
Transfers are run with three address patterns: a refused address, an acknowledged write address and an acknowledged read address. This separates the negative-ack path, the transmit stall and the receive stall. Reads are tried both with and without stall-enable. The no-stall case shows whether a receive starts by itself and whether a data-register read chains a second receive. The stall case shows whether the NACK request is taken from control1. A STOP is requested in three situations: directly after sending, while negative-ack is set, and before the final received byte is read. These show when the STOP may reach the engine. A second data write issued while the engine is busy, and control writes made while disabled, show that stimulus arriving at the wrong moment is dropped.

// File: rtl/smb_master_ctl.sv
module smb_master_ctl #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          cmd_valid,
  output logic [1:0]    cmd_op,
  output logic [DW-1:0] cmd_byte,
  output logic          cmd_nack,
  input  logic          eng_done,
  input  logic          eng_ack,
  input  logic [DW-1:0] eng_rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_DATA = AW'(5'h00);
  localparam logic [AW-1:0] A_ST   = AW'(5'h02);
  localparam logic [AW-1:0] A_CST  = AW'(5'h04);
  localparam logic [AW-1:0] A_C1   = AW'(5'h06);
  localparam logic [AW-1:0] A_C2   = AW'(5'h0A);
  localparam logic [AW-1:0] A_CST3 = AW'(5'h19);
  localparam logic [1:0] OP_START = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_STOP = 2'd3;

  logic en;
  logic [DW-1:0] ctl1_q, rxbuf;
  logic mode, xmit, sdast, negack, stastr, busy, eob;
  logic stop_pend, addr_ph, wr_addr, rd_dir, last_nak, eng_busy;
  logic [1:0] cur_op;

  wire wr_data = reg_wr && reg_addr == A_DATA;
  wire wr_st   = reg_wr && reg_addr == A_ST;
  wire wr_c1   = reg_wr && reg_addr == A_C1;
  wire wr_c2   = reg_wr && reg_addr == A_C2;
  wire wr_c3   = reg_wr && reg_addr == A_CST3;
  wire rd_data = reg_rd && reg_addr == A_DATA;

  wire stall_en = ctl1_q[7];
  wire nak_bit  = ctl1_q[4];
  wire eob_ie   = ctl1_q[3];
  wire ie       = ctl1_q[2];

  wire tx_ok    = mode && xmit && sdast && !stastr && !negack;
  wire rx_ready = mode && !xmit && sdast && !stastr;
  wire cont_rd  = eng_done && cur_op == OP_WR && wr_addr && eng_ack && rd_dir && !stall_en;

  logic go, go_nak;
  logic [1:0] go_op;

  always_comb begin
    go = 1'b0;
    go_op = OP_START;
    go_nak = nak_bit;
    if (en) begin
      if (cont_rd) begin
        go = 1'b1; go_op = OP_RD;
      end else if (!eng_busy) begin
        if (wr_c1 && reg_wdata[0]) begin
          go = 1'b1; go_op = OP_START;
        end else if (wr_data && tx_ok) begin
          go = 1'b1; go_op = OP_WR;
        end else if (wr_st && reg_wdata[3] && stastr && !xmit) begin
          go = 1'b1; go_op = OP_RD;
        end else if (rd_data && rx_ready && !stop_pend && !last_nak) begin
          go = 1'b1; go_op = OP_RD;
        end else if (stop_pend && !negack && !rx_ready) begin
          go = 1'b1; go_op = OP_STOP;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en <= 1'b0;
    else if (wr_c2) en <= reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1_q <= '0; rxbuf <= '0;
      {mode, xmit, sdast, negack, stastr, busy, eob} <= '0;
      {stop_pend, addr_ph, wr_addr, rd_dir, last_nak, eng_busy} <= '0;
      cur_op <= OP_START;
      cmd_valid <= 1'b0; cmd_op <= OP_START; cmd_byte <= '0; cmd_nack <= 1'b0;
    end else if (!en) begin
      ctl1_q <= '0;
      {mode, xmit, sdast, negack, stastr, busy, eob} <= '0;
      {stop_pend, addr_ph, wr_addr, rd_dir, last_nak, eng_busy} <= '0;
      cmd_valid <= 1'b0;
    end else begin
      cmd_valid <= go;
      if (wr_c1) begin
        ctl1_q <= {reg_wdata[7:2], 2'b00};
        if (reg_wdata[1] && busy) stop_pend <= 1'b1;
      end
      if (wr_st) begin
        if (reg_wdata[4]) negack <= 1'b0;
        if (reg_wdata[3]) stastr <= 1'b0;
      end
      if (wr_c3 && reg_wdata[7]) eob <= 1'b0;
      if (rd_data && rx_ready) sdast <= 1'b0;

      if (eng_done) begin
        eng_busy <= 1'b0;
        case (cur_op)
          OP_START: begin
            mode <= 1'b1; xmit <= 1'b1; sdast <= 1'b1;
            addr_ph <= 1'b1; last_nak <= 1'b0;
          end
          OP_WR: begin
            if (wr_addr) xmit <= !rd_dir;
            if (!eng_ack) negack <= 1'b1;
            else if (wr_addr && stall_en) begin
              stastr <= 1'b1; sdast <= 1'b1;
            end else if (!(wr_addr && rd_dir)) sdast <= 1'b1;
          end
          OP_RD: begin
            rxbuf <= eng_rdata; sdast <= 1'b1;
          end
          default: begin
            {mode, xmit, sdast, stastr, negack, busy} <= '0;
            {stop_pend, addr_ph, last_nak} <= '0;
            eob <= 1'b1;
          end
        endcase
      end

      if (go) begin
        eng_busy <= 1'b1;
        cur_op <= go_op;
        cmd_op <= go_op;
        cmd_byte <= reg_wdata;
        cmd_nack <= go_nak;
        case (go_op)
          OP_START: busy <= 1'b1;
          OP_WR: begin
            sdast <= 1'b0; wr_addr <= addr_ph; addr_ph <= 1'b0;
            if (addr_ph) rd_dir <= reg_wdata[0];
          end
          OP_RD: begin
            sdast <= 1'b0; last_nak <= go_nak;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = rxbuf;
      A_ST:    reg_rdata = {1'b0, sdast, 1'b0, negack, stastr, 1'b0, mode, xmit};
      A_CST:   reg_rdata = {6'b0, busy, busy};
      A_C1:    reg_rdata = ctl1_q;
      A_C2:    reg_rdata = {7'b0, en};
      A_CST3:  reg_rdata = {eob, 7'b0};
      default: reg_rdata = '0;
    endcase
  end

  assign irq = (ie && (sdast || negack || stastr)) || (eob_ie && eob);
endmodule

module smb_master_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       eng_done,
  input logic       eng_busy,
  input logic [1:0] cur_op,
  input logic       mode,
  input logic       xmit,
  input logic       sdast,
  input logic       negack,
  input logic       busy,
  input logic       eob
);
  // R1
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!mode && !busy && !eob && !cmd_valid));
  // R5
  stop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && eng_done && cur_op == 2'd3) |=> (eob && !busy && !mode));
  // R12
  stop_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3) |-> !(mode && !xmit && sdast));
  // R8
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && !eng_done) |=> !cmd_valid);
  // R4
  negack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(negack) |-> $past(eng_done));
endmodule

bind smb_master_ctl smb_master_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .eng_done(eng_done), .eng_busy(eng_busy), .cur_op(cur_op), .mode(mode),
  .xmit(xmit), .sdast(sdast), .negack(negack), .busy(busy), .eob(eob)
);

// File: tb/smb_master_ctl_test.sv
module smb_master_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [4:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic cmd_valid, cmd_nack;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;
  logic eng_done = 0, eng_ack = 0;
  logic [7:0] eng_rdata = 0;
  logic irq;

  int n_chk = 0, n_fail = 0;
  int n_start = 0, n_wr = 0, n_rd = 0, n_stop = 0;
  logic [7:0] last_byte = 0;
  logic last_nack = 0, after_start = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  smb_master_ctl uut (.*);

  initial begin : engine
    int pend;
    logic [1:0] op;
    logic [7:0] b;
    pend = 0; op = 0; b = 0;
    forever begin
      @(negedge clk);
      eng_done = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          eng_done = 1;
          eng_ack = (op == 2'd1) ? (after_start ? (b[7:1] == 7'h48) : 1'b1) : 1'b0;
          if (op == 2'd1) after_start = 0;
          eng_rdata = 8'h60;
        end
      end
      if (cmd_valid) begin
        op = cmd_op; b = cmd_byte; pend = 3;
        case (cmd_op)
          2'd0: begin n_start++; after_start = 1; end
          2'd1: begin n_wr++; last_byte = cmd_byte; end
          2'd2: begin n_rd++; last_nack = cmd_nack; end
          default: n_stop++;
        endcase
      end
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(5'h02, v); check("R1 status", v, 8'h00);
    rd(5'h04, v); check("R1 cst", v, 8'h00);
    rd(5'h19, v); check("R1 cst3", v, 8'h00);
    wr(5'h06, 8'h85); settle();
    rd(5'h06, v); check("R1 ctl1 ignored", v, 8'h00);
    check("R1 no start", 8'(n_start), 8'd0);
    check("R1 irq", {7'b0, irq}, 8'h00);
    wr(5'h0A, 8'h01);
    rd(5'h0A, v); check("R1 enable", v, 8'h01);
  endtask

  task automatic t_nack_addr();
    logic [7:0] v;
    wr(5'h06, 8'h85); settle();
    rd(5'h02, v); check("R2 status", v, 8'h43);
    rd(5'h04, v); check("R2 cst", v, 8'h03);
    check("R2 irq", {7'b0, irq}, 8'h01);
    rd(5'h06, v); check("R3 ctl1", v, 8'h84);
    wr(5'h00, 8'h02); settle();
    check("R7 addr byte", last_byte, 8'h02);
    rd(5'h02, v); check("R4 status", v, 8'h13);
    check("R4 irq", {7'b0, irq}, 8'h01);
    wr(5'h06, 8'h86); settle();
    rd(5'h06, v); check("R3 stop reads 0", v, 8'h84);
    rd(5'h04, v); check("R5 held cst", v, 8'h03);
    check("R5 no stop", 8'(n_stop), 8'd0);
    wr(5'h02, 8'h10); settle();
    rd(5'h02, v); check("R5 status", v, 8'h00);
    rd(5'h04, v); check("R5 cst", v, 8'h00);
    rd(5'h19, v); check("R5 eob", v, 8'h80);
    wr(5'h19, 8'h80);
    rd(5'h19, v); check("R6 eob clear", v, 8'h00);
  endtask

  task automatic t_write();
    logic [7:0] v;
    int w0;
    wr(5'h06, 8'h8D); settle();
    wr(5'h00, 8'h90); settle();
    check("R7 addr", last_byte, 8'h90);
    rd(5'h02, v); check("R7 stall", v, 8'h4B);
    wr(5'h02, 8'h08);
    rd(5'h02, v); check("R7 stall cleared", v, 8'h43);
    w0 = n_wr;
    wr(5'h00, 8'h01);
    wr(5'h00, 8'h55); settle();
    check("R8 one byte", 8'(n_wr - w0), 8'd1);
    check("R8 byte", last_byte, 8'h01);
    rd(5'h02, v); check("R8 status", v, 8'h43);
    wr(5'h06, 8'h8E); settle();
    rd(5'h02, v); check("R6 status", v, 8'h00);
    rd(5'h19, v); check("R6 eob", v, 8'h80);
    check("R6 eob irq", {7'b0, irq}, 8'h01);
    wr(5'h19, 8'h80);
    check("R6 irq off", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_read();
    logic [7:0] v;
    int s0, p0;
    s0 = n_start;
    wr(5'h06, 8'h85); settle();
    wr(5'h00, 8'h90); settle();
    wr(5'h02, 8'h08);
    wr(5'h00, 8'h01); settle();
    wr(5'h06, 8'h85); settle();
    rd(5'h02, v); check("R9 status", v, 8'h43);
    rd(5'h04, v); check("R9 cst", v, 8'h03);
    check("R9 starts", 8'(n_start - s0), 8'd2);
    wr(5'h00, 8'h91); settle();
    check("R7 read addr", last_byte, 8'h91);
    rd(5'h02, v); check("R10 status", v, 8'h4A);
    wr(5'h06, 8'h94);
    wr(5'h02, 8'h08); settle();
    rd(5'h02, v); check("R11 status", v, 8'h42);
    check("R11 nack", {7'b0, last_nack}, 8'h01);
    p0 = n_stop;
    wr(5'h06, 8'h96); settle();
    rd(5'h04, v); check("R12 busy held", v, 8'h03);
    check("R12 no stop", 8'(n_stop - p0), 8'd0);
    rd(5'h00, v); check("R11 data", v, 8'h60);
    settle();
    rd(5'h02, v); check("R12 status", v, 8'h00);
    rd(5'h04, v); check("R12 cst", v, 8'h00);
    rd(5'h19, v); check("R12 eob", v, 8'h80);
    check("R12 stop", 8'(n_stop - p0), 8'd1);
    wr(5'h19, 8'h80);
  endtask

  task automatic t_nostall();
    logic [7:0] v;
    int r0;
    wr(5'h06, 8'h05); settle();
    r0 = n_rd;
    wr(5'h00, 8'h91); settle();
    rd(5'h02, v); check("R13 status", v, 8'h42);
    check("R13 auto read", 8'(n_rd - r0), 8'd1);
    check("R13 ack", {7'b0, last_nack}, 8'h00);
    wr(5'h06, 8'h14);
    rd(5'h00, v); check("R13 data", v, 8'h60);
    settle();
    check("R13 chained", 8'(n_rd - r0), 8'd2);
    check("R13 nack", {7'b0, last_nack}, 8'h01);
    wr(5'h06, 8'h16); settle();
    rd(5'h00, v); settle();
    check("R13 no third", 8'(n_rd - r0), 8'd2);
    rd(5'h04, v); check("R13 cst", v, 8'h00);
    wr(5'h19, 8'h80);
  endtask

  task automatic t_disable();
    logic [7:0] v;
    wr(5'h06, 8'h85); settle();
    rd(5'h02, v); check("R2 again", v, 8'h43);
    wr(5'h0A, 8'h00);
    rd(5'h06, v); check("R1 ctl1", v, 8'h00);
    rd(5'h02, v); check("R1 status", v, 8'h00);
    rd(5'h04, v); check("R1 cst", v, 8'h00);
    rd(5'h19, v); check("R1 cst3", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_nack_addr();
    t_write();
    t_read();
    t_nostall();
    t_disable();
    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule